// File: doc/BRIEF.md
# Windowed Countdown Watchdog

A countdown watchdog for a system-on-chip safety monitor. Software first programs a 12-bit reload value and then starts the timer. Once started, the timer counts down on the module clock from (reload + 1) × 2^PRESCALE_W − 1 to zero. Software must service it before it reaches the end. If it does not, the block raises a one-cycle reset request and records the reason in a sticky status field. With the default PRESCALE_W of 13, the interval runs from 2^13 to 2^25 clock cycles.

Servicing takes two writes to the service port in order: the arm key 0xE51A, then the fire key 0xA35C. Any other word, or the right words in the wrong order, counts as a fault. An optional window mode also rejects a fire key that arrives while more than half of the interval is still left.

Each violation, of any kind, reloads the counter. The block keeps running, and the system reset logic decides what to do with the request.

Top module: `wdog_countdown`

## Requirements
- R1: Out of reset, rst_req_o is 0, status_o is 0b000, and the timer is stopped. While stopped it never raises a request.
- R2: Once started, the first request pulse appears exactly (reload+1)·2^PRESCALE_W cycles after the edge that wrote the start bit. The pulse sets status_o bit 0 (late service).
- R3: Each request pulse is one cycle wide. After a late-service pulse the counter reloads, and the next pulse follows one full interval later.
- R4: A fire key written right after an arm key reloads the counter without a pulse, and the next timeout comes one full interval after the fire-key edge. A service that lands on the same edge as the final count (counter at zero) wins over the timeout.
- R5: Any of these is a key fault: a first write other than 0xE51A, a repeated 0xE51A, or any word other than 0xA35C after 0xE51A. A key fault raises one pulse, sets status_o bit 2, reloads the counter and returns the sequence to its first step.
- R6: In window mode, a fire key accepted while the counter is at or above (reload+1)·2^(PRESCALE_W−1) raises a pulse and sets status_o bit 1 (early service). A fire key below that level is accepted silently.
- R7: Register select 1 is control: bit 0 starts the timer and bit 1 selects window mode. Once started, the timer cannot be stopped except by rst_ni.
- R8: The window-mode bit takes effect only in a control write made while the timer is stopped. Later control writes do not change it.
- R9: While the timer is stopped, writes to the service port are ignored: no pulse and no status change.
- R10: Register select 2 clears the status bits that are written as 1 and leaves the others alone. A violation that occurs on the same edge as a clear of its bit leaves the bit set.
- R11: Register select 0 writes the reload value (wdata[11:0]) at any time. The counter picks up the new value at its next reload, so the interval already under way is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock; the counter decrements on it |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 reload, 1 control, 2 status clear |
| reg_wdata_i | input | PRELOAD_W | Register write data |
| svc_we_i | input | 1 | Service key write strobe |
| svc_key_i | input | 16 | Service key word |
| rst_req_o | output | 1 | One-cycle reset request per violation |
| status_o | output | 3 | Sticky causes: bit 0 late, bit 1 early, bit 2 key |

## Verification
The bench runs with a prescale of 2^2. It sweeps every reload value to measure the first and second timeout intervals to the cycle; an off-by-one in the load value or in the zero detection would show up as a period one cycle long or short. In window mode it sweeps the fire-key position across every cycle of the interval for eight reload values, so a threshold compare of the wrong polarity or strictness flips the verdict at the boundary cycle. Service on the final count, clear-versus-set on the same edge, and a reload change in mid-interval are aimed at a priority or reload-timing mistake, which would produce a spurious pulse, a lost status bit or a wrong interval.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int          KEY_W    = 16;
  localparam logic [15:0] KEY_ARM  = 16'hE51A;
  localparam logic [15:0] KEY_FIRE = 16'hA35C;

  localparam logic [1:0] SEL_PRELOAD = 2'd0;
  localparam logic [1:0] SEL_CTRL    = 2'd1;
  localparam logic [1:0] SEL_CLR     = 2'd2;

  localparam int ST_LATE  = 0;
  localparam int ST_EARLY = 1;
  localparam int ST_KEY   = 2;
  localparam int ST_W     = 3;

  typedef enum logic {SEQ_IDLE, SEQ_ARMED} seq_state_e;
endpackage

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
  import wdog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             abort_i,
  input  logic             we_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             svc_ok_o,
  output logic             key_bad_o
);
  seq_state_e state_q, state_d;
  logic       wr;

  assign wr = en_i && we_i;

  always_comb begin
    svc_ok_o  = 1'b0;
    key_bad_o = 1'b0;
    if (wr) begin
      if (state_q == SEQ_IDLE) begin
        key_bad_o = (key_i != KEY_ARM);
      end else begin
        svc_ok_o  = (key_i == KEY_FIRE);
        key_bad_o = (key_i != KEY_FIRE);
      end
    end
  end

  always_comb begin
    state_d = state_q;
    if (!en_i || abort_i || svc_ok_o) state_d = SEQ_IDLE;
    else if (wr && state_q == SEQ_IDLE && key_i == KEY_ARM) state_d = SEQ_ARMED;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int PRELOAD_W  = 12,
  parameter int PRESCALE_W = 13,
  localparam int CNT_W     = PRELOAD_W + PRESCALE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 win_en_i,
  input  logic [PRELOAD_W-1:0] preload_i,
  input  logic                 svc_ok_i,
  input  logic                 reload_i,
  output logic [CNT_W-1:0]     cnt_o,
  output logic                 late_o,
  output logic                 early_o
);
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   load_val;
  logic [CNT_W-1:0]   win_thr;
  logic [PRELOAD_W:0] preload_inc;

  // (preload+1)*2^P - 1 is preload followed by P ones
  assign load_val    = {preload_i, {PRESCALE_W{1'b1}}};
  assign preload_inc = {1'b0, preload_i} + {{PRELOAD_W{1'b0}}, 1'b1};

  generate
    if (PRESCALE_W > 1) begin : g_thr_shift
      assign win_thr = CNT_W'(preload_inc) << (PRESCALE_W - 1);
    end else begin : g_thr_flat
      assign win_thr = CNT_W'(preload_inc);
    end
  endgenerate

  assign late_o  = en_i && (cnt_q == '0) && !svc_ok_i;
  assign early_o = svc_ok_i && win_en_i && (cnt_q >= win_thr);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (!en_i || reload_i || svc_ok_i) cnt_q <= load_val;
    else if (cnt_q != '0)                  cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/wdog_cfg_regs.sv
module wdog_cfg_regs
  import wdog_pkg::*;
#(
  parameter int PRELOAD_W = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [1:0]           sel_i,
  input  logic [PRELOAD_W-1:0] wdata_i,
  input  logic [ST_W-1:0]      viol_i,
  output logic [PRELOAD_W-1:0] preload_o,
  output logic                 en_o,
  output logic                 win_en_o,
  output logic [ST_W-1:0]      status_o
);
  logic [ST_W-1:0] clr;

  assign clr = (we_i && sel_i == SEL_CLR) ? wdata_i[ST_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      preload_o <= '0;
      en_o      <= 1'b0;
      win_en_o  <= 1'b0;
      status_o  <= '0;
    end else begin
      if (we_i && sel_i == SEL_PRELOAD) preload_o <= wdata_i;
      // control is locked once running
      if (we_i && sel_i == SEL_CTRL && !en_o) begin
        en_o     <= wdata_i[0];
        win_en_o <= wdata_i[1];
      end
      status_o <= (status_o & ~clr) | viol_i;
    end
  end
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown
  import wdog_pkg::*;
#(
  parameter int PRELOAD_W  = 12,
  parameter int PRESCALE_W = 13
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [1:0]           reg_sel_i,
  input  logic [PRELOAD_W-1:0] reg_wdata_i,
  input  logic                 svc_we_i,
  input  logic [15:0]          svc_key_i,
  output logic                 rst_req_o,
  output logic [2:0]           status_o
);
  localparam int CNT_W = PRELOAD_W + PRESCALE_W;

  logic [PRELOAD_W-1:0] preload_q;
  logic                 en_q;
  logic                 win_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 svc_ok;
  logic                 key_bad;
  logic                 late;
  logic                 early;
  logic [ST_W-1:0]      viol;
  logic                 viol_any;
  logic                 rst_req_q;

  assign viol[ST_LATE]  = late;
  assign viol[ST_EARLY] = early;
  assign viol[ST_KEY]   = key_bad;
  assign viol_any       = |viol;

  wdog_cfg_regs #(.PRELOAD_W(PRELOAD_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .sel_i     (reg_sel_i),
    .wdata_i   (reg_wdata_i),
    .viol_i    (viol),
    .preload_o (preload_q),
    .en_o      (en_q),
    .win_en_o  (win_q),
    .status_o  (status_o)
  );

  wdog_key_seq u_keys (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_q),
    .abort_i   (viol_any),
    .we_i      (svc_we_i),
    .key_i     (svc_key_i),
    .svc_ok_o  (svc_ok),
    .key_bad_o (key_bad)
  );

  wdog_counter #(.PRELOAD_W(PRELOAD_W), .PRESCALE_W(PRESCALE_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_q),
    .win_en_i  (win_q),
    .preload_i (preload_q),
    .svc_ok_i  (svc_ok),
    .reload_i  (viol_any),
    .cnt_o     (cnt_q),
    .late_o    (late),
    .early_o   (early)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_req_q <= 1'b0;
    else         rst_req_q <= viol_any;
  end

  assign rst_req_o = rst_req_q;
endmodule

// File: rtl/wdog_countdown_chk.sv
module wdog_countdown_chk #(
  parameter int CNT_W = 25
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rst_req_o,
  input logic [2:0]       status_o,
  input logic             en_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             svc_ok
);
  AST_EN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> en_q); // R7

  AST_LATE_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && cnt_q == '0 && !svc_ok) |=> (rst_req_o && status_o[0])); // R2

  AST_REQ_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (status_o != 3'b000)); // R3

  AST_STOPPED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> !rst_req_o); // R9

  AST_STATUS_SET_WITH_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o & ~$past(status_o)) != 3'b000) |-> rst_req_o); // R10

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && $past(en_q) && !rst_req_o && !$past(svc_ok) && $past(cnt_q) != '0)
      |-> (cnt_q == $past(cnt_q) - 1'b1)); // R2
endmodule

bind wdog_countdown wdog_countdown_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rst_req_o (rst_req_o),
  .status_o  (status_o),
  .en_q      (en_q),
  .cnt_q     (cnt_q),
  .svc_ok    (svc_ok)
);

// File: tb/wdog_countdown_test.sv
`timescale 1ns/1ps
module wdog_countdown_test;
  import wdog_pkg::*;

  localparam int PW = 4;
  localparam int SW = 2;
  localparam int SCALE = 1 << SW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_we_i = 1'b0;
  logic [1:0]    reg_sel_i = '0;
  logic [PW-1:0] reg_wdata_i = '0;
  logic          svc_we_i = 1'b0;
  logic [15:0]   svc_key_i = '0;
  logic          rst_req_o;
  logic [2:0]    status_o;

  int total = 0;
  int bad = 0;

  always #2 clk_i = ~clk_i;

  wdog_countdown #(.PRELOAD_W(PW), .PRESCALE_W(SW)) uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_sel_i   (reg_sel_i),
    .reg_wdata_i (reg_wdata_i),
    .svc_we_i    (svc_we_i),
    .svc_key_i   (svc_key_i),
    .rst_req_o   (rst_req_o),
    .status_o    (status_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic do_reset();
    rst_ni = 1'b0; reg_we_i = 1'b0; svc_we_i = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wr(input logic [1:0] sel, input int data);
    reg_sel_i = sel; reg_wdata_i = PW'(data); reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic key1(input logic [15:0] k);
    svc_key_i = k; svc_we_i = 1'b1;
    @(negedge clk_i);
    svc_we_i = 1'b0;
  endtask

  task automatic key2(input logic [15:0] a, input logic [15:0] b);
    svc_key_i = a; svc_we_i = 1'b1;
    @(negedge clk_i);
    svc_key_i = b;
    @(negedge clk_i);
    svc_we_i = 1'b0;
  endtask

  task automatic wait_req(output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!rst_req_o && n < 1000);
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int pulses;
    @(negedge clk_i);
    do_reset();

    // R1 / R9: reset state and stopped timer ignores service writes
    chk("R1 rst_req", int'(rst_req_o), 0);
    chk("R1 status", int'(status_o), 0);
    key2(KEY_FIRE, KEY_FIRE);
    key1(16'h1234);
    key2(KEY_ARM, KEY_FIRE);
    pulses = 0;
    for (int i = 0; i < 100; i++) begin
      if (rst_req_o) pulses++;
      @(negedge clk_i);
    end
    chk("R1 stopped pulses", pulses, 0);
    chk("R9 status after keys", int'(status_o), 0);

    // R2 / R3: timeout period over every reload value
    for (int p = 0; p < (1 << PW); p++) begin
      do_reset();
      wr(SEL_PRELOAD, p);
      wr(SEL_CTRL, 1);
      wait_req(n);
      chk($sformatf("R2 period p=%0d", p), n, (p + 1) * SCALE);
      chk("R2 late bit", int'(status_o), 1);
      @(negedge clk_i);
      chk("R3 pulse width", int'(rst_req_o), 0);
      wait_req(n);
      chk($sformatf("R3 second period p=%0d", p), n + 1, (p + 1) * SCALE);
    end

    // R4: service mid-interval then timing of next timeout
    do_reset();
    wr(SEL_PRELOAD, 5);
    wr(SEL_CTRL, 1);
    repeat (10) @(negedge clk_i);
    key2(KEY_ARM, KEY_FIRE);
    chk("R4 no pulse", int'(rst_req_o), 0);
    wait_req(n);
    chk("R4 period after service", n, 6 * SCALE);

    // R4: service on the final count beats the timeout
    do_reset();
    wr(SEL_PRELOAD, 2);
    wr(SEL_CTRL, 1);
    repeat (3 * SCALE - 2) @(negedge clk_i);
    key2(KEY_ARM, KEY_FIRE);
    chk("R4 last count pulse", int'(rst_req_o), 0);
    chk("R4 last count status", int'(status_o), 0);
    wait_req(n);
    chk("R4 last count period", n, 3 * SCALE);

    // R5: key faults
    do_reset();
    wr(SEL_PRELOAD, 7);
    wr(SEL_CTRL, 1);
    key1(KEY_FIRE);
    chk("R5 fire first pulse", int'(rst_req_o), 1);
    chk("R5 fire first status", int'(status_o), 4);
    wait_req(n);
    chk("R5 reload on fault", n, 8 * SCALE);
    wr(SEL_CLR, 7);
    key2(KEY_ARM, KEY_ARM);
    chk("R5 double arm pulse", int'(rst_req_o), 1);
    chk("R5 double arm status", int'(status_o), 4);
    wr(SEL_CLR, 4);
    key2(KEY_ARM, 16'h1234);
    chk("R5 bad second pulse", int'(rst_req_o), 1);
    chk("R5 bad second status", int'(status_o), 4);
    wr(SEL_CLR, 4);
    key2(KEY_ARM, KEY_FIRE);
    chk("R5 recover pulse", int'(rst_req_o), 0);
    chk("R5 recover status", int'(status_o), 0);

    // R6: window sweep over every service position
    for (int p = 0; p < 8; p++) begin
      for (int d = 0; d <= (p + 1) * SCALE - 2; d++) begin
        int nn;
        int early;
        nn = (p + 1) * SCALE;
        early = ((nn - 2 - d) >= nn / 2) ? 1 : 0;
        do_reset();
        wr(SEL_PRELOAD, p);
        wr(SEL_CTRL, 3);
        repeat (d) @(negedge clk_i);
        key2(KEY_ARM, KEY_FIRE);
        chk($sformatf("R6 pulse p=%0d d=%0d", p, d), int'(rst_req_o), early);
        chk($sformatf("R6 status p=%0d d=%0d", p, d), int'(status_o), early * 2);
      end
    end

    // R7: start cannot be undone
    do_reset();
    wr(SEL_PRELOAD, 1);
    wr(SEL_CTRL, 1);
    wr(SEL_CTRL, 0);
    wait_req(n);
    chk("R7 still running", n + 1, 2 * SCALE);

    // R8: window bit locked after start
    do_reset();
    wr(SEL_PRELOAD, 3);
    wr(SEL_CTRL, 1);
    wr(SEL_CTRL, 3);
    key2(KEY_ARM, KEY_FIRE);
    chk("R8 no early pulse", int'(rst_req_o), 0);
    chk("R8 no early status", int'(status_o), 0);

    // R10: write-one-to-clear and set priority
    do_reset();
    wr(SEL_PRELOAD, 15);
    wr(SEL_CTRL, 1);
    wait_req(n);
    chk("R10 late set", int'(status_o), 1);
    key1(KEY_FIRE);
    chk("R10 both set", int'(status_o), 5);
    wr(SEL_CLR, 1);
    chk("R10 clear bit0 only", int'(status_o), 4);
    wr(SEL_CLR, 4);
    chk("R10 clear bit2", int'(status_o), 0);
    key1(KEY_FIRE);
    chk("R10 key set again", int'(status_o), 4);
    reg_sel_i = SEL_CLR; reg_wdata_i = PW'(4); reg_we_i = 1'b1;
    svc_key_i = KEY_FIRE; svc_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0; svc_we_i = 1'b0;
    chk("R10 set beats clear", int'(status_o), 4);
    chk("R10 set beats clear pulse", int'(rst_req_o), 1);

    // R11: reload change applies at next reload
    do_reset();
    wr(SEL_PRELOAD, 1);
    wr(SEL_CTRL, 1);
    wr(SEL_PRELOAD, 3);
    wait_req(n);
    chk("R11 current interval kept", n + 1, 2 * SCALE);
    wait_req(n);
    chk("R11 new interval", n, 4 * SCALE);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule